// File: doc/BRIEF.md
# Paged address translation map

This block sits between a network controller that issues 24-bit addresses and a small local RAM. It holds a table of page entries that the host programs through a 16-bit register port. Each lookup takes a slot index from the address, reads the matching entry and produces three things: a physical RAM address, a select between on-board and auxiliary-bus memory, and a byte-order control. When the entry asks for little-endian order, the block also exchanges the two bytes of each 16-bit data word in both directions. The host's own accesses to board memory go through the same lookup port, so both masters see the same view of RAM.

The page size is 1 KiB, the table has 1024 slots, and the on-board RAM holds 256 frames. The controller fetches its boot pointer from the top of its address space. Software can therefore point the last slot at frame 0, so that one physical page appears both at address 0 and at the top of the space.

Top module: `pagemap_top`

## Requirements
- R1: After reset every map entry reads as 0x0000. A lookup through any slot then gives frame 0, on-board memory, little-endian order, no range error and an enabled access.
- R2: When `hostWrEn` is high, the entry at slot `hostIdx` is written with `hostWrData`. When `hostRdEn` is high, that slot's entry appears on `hostRdData` one cycle later, with `hostRdValid` high in the same cycle.
- R3: Address bits [23:20] have no effect on a lookup. Bits [19:10] select the slot, and bits [9:0] pass unchanged to `xlAddr[9:0]`. `xlAddr[17:10]` is the low 8 bits of the entry's frame number.
- R4: `xlValid` is high exactly in the cycle after a cycle with `lookValid` high, and all translation outputs belong to that lookup.
- R5: Entry bit 15 drives `xlHostOrder` (1 = host big-endian order). Bit 13 drives `xlAuxSel` (1 = auxiliary-bus memory). Bits [11:0] are the frame number.
- R6: A lookup that selects on-board memory with a frame number of 256 or more raises `xlOutOfRange` and holds `xlAccessEn` low. Frame 255 on board, and any frame on auxiliary memory, is in range, and its access is enabled.
- R7: On the write path, `xlWrData` equals the lookup's `lookWrData` when bit 15 is 1, and has its two bytes exchanged when bit 15 is 0.
- R8: On the read path, `xlRdData` equals `memRdData` when bit 15 is 1, and has its two bytes exchanged when bit 15 is 0.
- R9: A lookup in the same cycle as a host write to its slot uses the old entry. A lookup in the next cycle uses the new entry.
- R10: If slot 1023 and slot 0 both map frame 0, address 0xFFFFF4 and address 0x0003F4 both translate to physical address 0x003F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host entry write strobe |
| hostRdEn | input | 1 | Host entry read strobe |
| hostIdx | input | 10 | Slot (word offset) for host access |
| hostWrData | input | 16 | Entry value to write |
| hostRdData | output | 16 | Entry value read back |
| hostRdValid | output | 1 | hostRdData valid |
| lookValid | input | 1 | Lookup request |
| lookAddr | input | 24 | Address to translate |
| lookWrData | input | 16 | Write data of the access being translated |
| memRdData | input | 16 | Data returned by RAM for the translated access |
| xlValid | output | 1 | Translation outputs valid |
| xlAddr | output | 18 | Physical RAM address {frame[7:0], offset} |
| xlAuxSel | output | 1 | 1 = auxiliary-bus memory |
| xlHostOrder | output | 1 | 1 = data passes without byte exchange |
| xlOutOfRange | output | 1 | On-board frame beyond RAM |
| xlAccessEn | output | 1 | Access may proceed |
| xlWrData | output | 16 | Lane-corrected write data toward RAM |
| xlRdData | output | 16 | Lane-corrected read data from RAM |

## Verification
The bench sets the top address nibble to values other than zero and expects identical results. A design that decoded all 24 bits would pick a different slot. It probes frames 255 and 256 on board, and frame 256 on auxiliary memory. An off-by-one or unconditional range check would then either block a legal access or let an access past the end of RAM. A lookup issued in the same cycle as a write to its slot shows whether the read port returns stale or new data. A lane swap keyed to the wrong polarity, or applied to only one direction, shows up as wrong data on one path. The alias case programs the top slot to frame 0 and checks the boot-pointer address against its low twin.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;

  typedef struct packed {
    logic        hostOrder;
    logic        rsvA;
    logic        auxMem;
    logic        rsvB;
    logic [11:0] frame;
  } mapEntry_t;

  typedef struct packed {
    logic hostWr;
    logic hostRd;
    logic look;
  } mapStrobe_t;

  function automatic logic [15:0] laneSwap(input logic [15:0] w, input logic keep);
    return keep ? w : {w[7:0], w[15:8]};
  endfunction

endpackage

// File: rtl/pagemap_ctrl.sv
module pagemap_ctrl
  import pagemap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic       lookValid,
  input  logic       rangeErr,
  output mapStrobe_t strobe,
  output logic       hostRdValid,
  output logic       xlValid,
  output logic       xlAccessEn
);

  always_comb begin
    strobe.hostWr = hostWrEn;
    strobe.hostRd = hostRdEn;
    strobe.look   = lookValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hostRdValid <= 1'b0;
      xlValid     <= 1'b0;
    end else begin
      hostRdValid <= hostRdEn;
      xlValid     <= lookValid;
    end
  end

  assign xlAccessEn = xlValid & ~rangeErr;

  AST_HOST_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    hostRdEn |=> hostRdValid); // R2
  AST_LOOK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    lookValid |=> xlValid); // R4
  AST_LOOK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lookValid |=> !xlValid); // R4

endmodule

// File: rtl/pagemap_datapath.sv
module pagemap_datapath
  import pagemap_pkg::*;
#(
  parameter int SLOTS    = 1024,
  parameter int OFF_W    = 10,
  parameter int ADDR_W   = 24,
  parameter int BFRAME_W = 8,
  parameter int DATA_W   = 16,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int PHYS_W  = BFRAME_W + OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  mapStrobe_t        strobe,
  input  logic [SLOT_W-1:0] hostIdx,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic [DATA_W-1:0] lookWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] hostRdData,
  output logic [PHYS_W-1:0] xlAddr,
  output logic              xlAuxSel,
  output logic              xlHostOrder,
  output logic              rangeErr,
  output logic [DATA_W-1:0] xlWrData,
  output logic [DATA_W-1:0] xlRdData
);

  mapEntry_t         mapMem [SLOTS];
  mapEntry_t         entryQ;
  logic [OFF_W-1:0]  offsetQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [SLOT_W-1:0] lookSlot;

  assign lookSlot = lookAddr[OFF_W +: SLOT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mapMem[i] <= '0;
    end else if (strobe.hostWr) begin
      mapMem[hostIdx] <= mapEntry_t'(hostWrData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hostRdData <= '0;
      entryQ     <= '0;
      offsetQ    <= '0;
      wrDataQ    <= '0;
    end else begin
      if (strobe.hostRd) hostRdData <= DATA_W'(mapMem[hostIdx]);
      if (strobe.look) begin
        entryQ  <= mapMem[lookSlot];
        offsetQ <= lookAddr[OFF_W-1:0];
        wrDataQ <= lookWrData;
      end
    end
  end

  assign xlAddr      = {entryQ.frame[BFRAME_W-1:0], offsetQ};
  assign xlAuxSel    = entryQ.auxMem;
  assign xlHostOrder = entryQ.hostOrder;
  assign rangeErr    = ~entryQ.auxMem & (entryQ.frame[11:BFRAME_W] != '0);
  assign xlWrData    = laneSwap(wrDataQ, entryQ.hostOrder);
  assign xlRdData    = laneSwap(memRdData, entryQ.hostOrder);

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe.hostWr) && strobe.hostRd && !strobe.hostWr && hostIdx == $past(hostIdx))
      |=> hostRdData == $past(hostWrData, 2)); // R2
  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.look |=> xlAddr[OFF_W-1:0] == $past(lookAddr[OFF_W-1:0])); // R3

endmodule

// File: rtl/pagemap_top.sv
module pagemap_top
  import pagemap_pkg::*;
#(
  parameter int SLOTS       = 1024,
  parameter int OFF_W       = 10,
  parameter int ADDR_W      = 24,
  parameter int BOARD_PAGES = 256,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int BFRAME_W   = $clog2(BOARD_PAGES),
  localparam int PHYS_W     = BFRAME_W + OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [SLOT_W-1:0] hostIdx,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  output logic              hostRdValid,
  input  logic              lookValid,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic [15:0]       lookWrData,
  input  logic [15:0]       memRdData,
  output logic              xlValid,
  output logic [PHYS_W-1:0] xlAddr,
  output logic              xlAuxSel,
  output logic              xlHostOrder,
  output logic              xlOutOfRange,
  output logic              xlAccessEn,
  output logic [15:0]       xlWrData,
  output logic [15:0]       xlRdData
);

  mapStrobe_t strobe;
  logic       rangeErr;

  pagemap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .lookValid(lookValid), .rangeErr(rangeErr), .strobe(strobe),
    .hostRdValid(hostRdValid), .xlValid(xlValid), .xlAccessEn(xlAccessEn)
  );

  pagemap_datapath #(
    .SLOTS(SLOTS), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .BFRAME_W(BFRAME_W), .DATA_W(16)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .hostIdx(hostIdx),
    .hostWrData(hostWrData), .lookAddr(lookAddr), .lookWrData(lookWrData),
    .memRdData(memRdData), .hostRdData(hostRdData), .xlAddr(xlAddr),
    .xlAuxSel(xlAuxSel), .xlHostOrder(xlHostOrder), .rangeErr(rangeErr),
    .xlWrData(xlWrData), .xlRdData(xlRdData)
  );

  assign xlOutOfRange = xlValid & rangeErr;

  AST_ACCESS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xlAccessEn |-> (xlValid && !xlOutOfRange)); // R6
  AST_RANGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    xlOutOfRange |-> !xlAccessEn); // R6

endmodule

// File: tb/sim_pagemap_top.sv
module sim_pagemap_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        hostWrEn = 0, hostRdEn = 0;
  logic [9:0]  hostIdx = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        hostRdValid;
  logic        lookValid = 0;
  logic [23:0] lookAddr = '0;
  logic [15:0] lookWrData = '0, memRdData = '0;
  logic        xlValid, xlAuxSel, xlHostOrder, xlOutOfRange, xlAccessEn;
  logic [17:0] xlAddr;
  logic [15:0] xlWrData, xlRdData;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagemap_top u0 (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input int idx, input logic [15:0] v);
    @(negedge clk);
    hostWrEn = 1; hostIdx = 10'(idx); hostWrData = v;
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic hostReadChk(input string req, input int idx, input logic [15:0] exp);
    @(negedge clk);
    hostRdEn = 1; hostIdx = 10'(idx);
    @(negedge clk);
    hostRdEn = 0;
    chk(req, "hostRdValid", hostRdValid, 1);
    chk(req, "hostRdData", hostRdData, exp);
  endtask

  // issue a lookup, sample outputs one cycle later
  task automatic lookup(input logic [23:0] a, input logic [15:0] wd, input logic [15:0] rd);
    @(negedge clk);
    lookValid = 1; lookAddr = a; lookWrData = wd;
    @(negedge clk);
    lookValid = 0; memRdData = rd;
    #1;
  endtask

  function automatic logic [17:0] expPhys(input logic [15:0] e, input logic [23:0] a);
    return {e[7:0], a[9:0]};
  endfunction

  function automatic logic [15:0] sw(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic t_reset();
    chk("R1", "xlValid idle", xlValid, 0);
    hostReadChk("R1", 0, 16'h0000);
    hostReadChk("R1", 1023, 16'h0000);
    lookup(24'h123456, 16'h1234, 16'h5678);
    chk("R1", "xlAddr", xlAddr, expPhys(16'h0, 24'h123456));
    chk("R1", "order", xlHostOrder, 0);
    chk("R1", "aux", xlAuxSel, 0);
    chk("R1", "range", xlOutOfRange, 0);
    chk("R1", "access", xlAccessEn, 1);
  endtask

  task automatic t_hostrw();
    hostWrite(5, 16'h8007);
    hostWrite(6, 16'hA5F3);
    hostReadChk("R2", 5, 16'h8007);
    hostReadChk("R2", 6, 16'hA5F3);
    @(negedge clk);
    chk("R2", "hostRdValid drop", hostRdValid, 0);
  endtask

  task automatic t_translate();
    logic [23:0] a;
    a = 24'h7294F3;  // slot 0x0A5, offset 0x0F3
    hostWrite(10'h0A5, 16'h803C);
    @(negedge clk);
    chk("R4", "xlValid before", xlValid, 0);
    lookup(a, 16'h0, 16'h0);
    chk("R4", "xlValid", xlValid, 1);
    chk("R3", "xlAddr high nibble 7", xlAddr, expPhys(16'h803C, a));
    chk("R5", "order", xlHostOrder, 1);
    chk("R5", "aux", xlAuxSel, 0);
    lookup(24'h0294F3, 16'h0, 16'h0);
    chk("R3", "xlAddr high nibble 0", xlAddr, expPhys(16'h803C, a));
    lookup(24'hF294F3, 16'h0, 16'h0);
    chk("R3", "xlAddr high nibble F", xlAddr, expPhys(16'h803C, a));
    @(negedge clk);
    chk("R4", "xlValid after", xlValid, 0);
  endtask

  task automatic t_range();
    hostWrite(7, 16'h0100);
    hostWrite(8, 16'h2100);
    hostWrite(9, 16'h00FF);
    lookup(24'h001C10, 16'h0, 16'h0);
    chk("R6", "frame256 onboard range", xlOutOfRange, 1);
    chk("R6", "frame256 onboard access", xlAccessEn, 0);
    lookup(24'h002010, 16'h0, 16'h0);
    chk("R6", "aux range", xlOutOfRange, 0);
    chk("R6", "aux access", xlAccessEn, 1);
    chk("R5", "aux sel", xlAuxSel, 1);
    lookup(24'h002410, 16'h0, 16'h0);
    chk("R6", "frame255 range", xlOutOfRange, 0);
    chk("R6", "frame255 access", xlAccessEn, 1);
    chk("R3", "frame255 addr", xlAddr, 18'h3FC10);
  endtask

  task automatic t_swap();
    hostWrite(3, 16'h8002);
    hostWrite(4, 16'h0002);
    lookup(24'h000C22, 16'hA1B2, 16'hC3D4);
    chk("R7", "host order write", xlWrData, 16'hA1B2);
    chk("R8", "host order read", xlRdData, 16'hC3D4);
    lookup(24'h001022, 16'hA1B2, 16'hC3D4);
    chk("R7", "swapped write", xlWrData, sw(16'hA1B2));
    chk("R8", "swapped read", xlRdData, sw(16'hC3D4));
  endtask

  task automatic t_visibility();
    @(negedge clk);
    hostWrEn = 1; hostIdx = 10'd12; hostWrData = 16'h8011;
    lookValid = 1; lookAddr = 24'h003005;
    @(negedge clk);
    hostWrEn = 0;
    #1;
    chk("R9", "same-cycle old order", xlHostOrder, 0);
    chk("R9", "same-cycle old addr", xlAddr, 18'h00005);
    @(negedge clk);
    lookValid = 0;
    #1;
    chk("R9", "next-cycle new order", xlHostOrder, 1);
    chk("R9", "next-cycle new addr", xlAddr, expPhys(16'h8011, 24'h003005));
  endtask

  task automatic t_alias();
    hostWrite(1023, 16'h8000);
    hostWrite(0, 16'h8000);
    lookup(24'hFFFFF4, 16'h0, 16'h0);
    chk("R10", "top alias", xlAddr, 18'h003F4);
    lookup(24'h0003F4, 16'h0, 16'h0);
    chk("R10", "low page", xlAddr, 18'h003F4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hostrw();
    t_translate();
    t_range();
    t_swap();
    t_visibility();
    t_alias();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule